// File: doc/BRIEF.md
# Programmable AND-OR Array

This block is the logic core of a small reprogrammable registered logic device. It takes twelve dedicated input signals and ten feedback signals from the output cells. It forms a true and a complemented literal from each of these 22 signals, which gives 44 literal columns. It then evaluates 132 product terms, each through a row of programmable connection bits. The terms are grouped into ten per-cell OR sums of unequal size, ten per-cell output-enable terms, one global asynchronous-reset term and one global synchronous-preset term. The output cells, the pin drivers and the clock pin are outside this block.

The path from literals to outputs is purely combinational. The only clocked logic is the configuration chain and its small controller. The connection bits enter one per clock through a serial shift chain while `cfg_load` is high. The controller has three states:
- `ST_EMPTY` is entered on reset. The array has not been configured yet.
- `ST_LOAD` means bits are being shifted in.
- `ST_RUN` means the array is live.

Its transitions are:
- `EMPTY_TO_LOAD`: `cfg_load` high while in `ST_EMPTY`.
- `LOAD_TO_LOAD`: `cfg_load` still high while in `ST_LOAD`.
- `LOAD_TO_RUN`: `cfg_load` low while in `ST_LOAD`.
- `RUN_TO_LOAD`: `cfg_load` high while in `ST_RUN`.
- `ST_EMPTY` and `ST_RUN` hold when `cfg_load` is low.

Top module: `sop_array`

## Requirements
- R1: Array input k (0..21) is `ded_in[k]` for k < 12 and `fb_in[k-12]` otherwise. Literal column 2k carries input k true, and column 2k+1 carries it complemented.
- R2: A product term is the AND of the literals whose connection bit is 1. A term with no bit set evaluates to 1. A term that connects both columns of one input evaluates to 0.
- R3: Output cell c has 8+2*min(c,9-c) sum terms, which gives 8,10,12,14,16,16,14,12,10,8. Its block of rows starts at row 1+Σ_{j<c}(1+terms_j). The block's first row is the enable term, and the next terms_c rows feed `sum_out[c]`, which is their OR.
- R4: `oe_out[c]` is the value of the first row of cell c's block.
- R5: `ar_out` is row 0 (asynchronous reset for all cells), and `sp_out` is row 131 (synchronous preset for all cells).
- R6: The connection bit for row r and column k sits at flat chain index r*44+k. On each clock with `cfg_load` high, every bit moves up one index, `cfg_bit` enters at index 0, and index 5807 is dropped. After 5808 load clocks, the first bit shifted in sits at index 5807.
- R7: While `cfg_load` is low, `cfg_bit` has no effect: the stored connection bits and the outputs do not depend on it.
- R8: In `ST_EMPTY` (after reset) and in `ST_LOAD`, all of `sum_out`, `oe_out`, `ar_out` and `sp_out` are 0. Reset clears the chain to all zeros.
- R9: The controller follows the transitions listed above, and outputs become live on the first cycle after `cfg_load` falls.
- R10: In `ST_RUN`, the outputs follow `ded_in` and `fb_in` within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and its controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data bit |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback inputs from the output cells |
| sum_out | output | 10 | Per-cell OR sums |
| oe_out | output | 10 | Per-cell output-enable terms |
| ar_out | output | 1 | Global asynchronous-reset term |
| sp_out | output | 1 | Global synchronous-preset term |

## Verification
Live evaluation and the start of a new load can fall in the same cycle. This happens when `cfg_load` rises while the array is in `ST_RUN`. The bench provokes this mid-run, with fresh random inputs driven in that same cycle. It expects the outputs to stay live and correct for that cycle and to blank from the next edge. Short aborted reloads that shift only a few bits are also provoked, so that the following run exposes any error in how bits move through the chain. Every cycle is judged against a behavioural model: a bit queue for the chain and a loop evaluation of the product terms.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } cfg_state_e;

    // Sum-term count of cell c: grows by tstep toward the middle, symmetric
    function automatic int cell_terms(input int c, input int ncell,
                                      input int tmin, input int tstep);
        int d;
        d = (c < ncell - 1 - c) ? c : ncell - 1 - c;
        return tmin + tstep * d;
    endfunction

    // First row (enable term) of cell c; row 0 is the global reset term
    function automatic int cell_base(input int c, input int ncell,
                                     input int tmin, input int tstep);
        int b;
        b = 1;
        for (int j = 0; j < c; j++)
            b += 1 + cell_terms(j, ncell, tmin, tstep);
        return b;
    endfunction

    // All cell blocks plus the reset row and the preset row
    function automatic int total_rows(input int ncell, input int tmin,
                                      input int tstep);
        return cell_base(ncell, ncell, tmin, tstep) + 1;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain
    import sop_array_pkg::*;
#(
    parameter int CHAIN = 5808
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             load_bit,
    output logic [CHAIN-1:0] chain_o,
    output logic             ready_o
);

    cfg_state_e       st_q, st_d;
    logic [CHAIN-1:0] chain_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (load_en) st_d = ST_LOAD;
            ST_LOAD:  if (!load_en) st_d = ST_RUN;
            ST_RUN:   if (load_en) st_d = ST_LOAD;
            default:  st_d = ST_EMPTY;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        unique case (st_q)
            ST_RUN:  ready_o = 1'b1;
            default: ready_o = 1'b0;
        endcase
    end

    // Serial chain: newest bit at index 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       chain_q <= '0;
        else if (load_en) chain_q <= {chain_q[CHAIN-2:0], load_bit};
    end

    assign chain_o = chain_q;

    p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(chain_q));
    p_load_blanks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !ready_o);
    p_load_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOAD && !load_en) |=> ready_o);
    p_empty_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMPTY && !load_en) |=> !ready_o);

endmodule

// File: rtl/sop_literals.sv
module sop_literals #(
    parameter int N_IN = 22
) (
    input  logic [N_IN-1:0]   in_i,
    output logic [2*N_IN-1:0] lit_o
);

    for (genvar k = 0; k < N_IN; k++) begin : g_lit
        assign lit_o[2*k]   = in_i[k];
        assign lit_o[2*k+1] = ~in_i[k];
    end

endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
    parameter int N_COL = 44
) (
    input  logic [N_COL-1:0] lit_i,
    input  logic [N_COL-1:0] conn_i,
    output logic             term_o
);

    // Unconnected columns read as 1, so an empty row is 1
    assign term_o = &(lit_i | ~conn_i);

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_array_pkg::*;
#(
    parameter int N_DED     = 12,
    parameter int N_CELL    = 10,
    parameter int MIN_TERMS = 8,
    parameter int TERM_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_bit,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_CELL-1:0] fb_in,
    output logic [N_CELL-1:0] sum_out,
    output logic [N_CELL-1:0] oe_out,
    output logic              ar_out,
    output logic              sp_out
);

    localparam int N_IN   = N_DED + N_CELL;
    localparam int N_COL  = 2 * N_IN;
    localparam int N_ROW  = total_rows(N_CELL, MIN_TERMS, TERM_STEP);
    localparam int CHAIN  = N_ROW * N_COL;
    localparam int AR_ROW = 0;
    localparam int SP_ROW = N_ROW - 1;

    logic [CHAIN-1:0]  chain;
    logic              cfg_ready;
    logic [N_COL-1:0]  lits;
    logic [N_ROW-1:0]  term;
    logic [N_CELL-1:0] sum_raw, oe_raw;

    sop_cfg_chain #(.CHAIN(CHAIN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cfg_load),
        .load_bit (cfg_bit),
        .chain_o  (chain),
        .ready_o  (cfg_ready)
    );

    sop_literals #(.N_IN(N_IN)) u_lits (
        .in_i  ({fb_in, ded_in}),
        .lit_o (lits)
    );

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        sop_pterm #(.N_COL(N_COL)) u_pt (
            .lit_i  (lits),
            .conn_i (chain[r*N_COL +: N_COL]),
            .term_o (term[r])
        );
    end

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        localparam int BASE = cell_base(c, N_CELL, MIN_TERMS, TERM_STEP);
        localparam int NT   = cell_terms(c, N_CELL, MIN_TERMS, TERM_STEP);
        assign oe_raw[c]  = term[BASE];
        assign sum_raw[c] = |term[BASE+1 +: NT];
    end

    // Nothing leaves the array until a load has completed
    assign sum_out = cfg_ready ? sum_raw : '0;
    assign oe_out  = cfg_ready ? oe_raw  : '0;
    assign ar_out  = cfg_ready & term[AR_ROW];
    assign sp_out  = cfg_ready & term[SP_ROW];

    p_blank_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> (sum_out == '0 && oe_out == '0 && !ar_out && !sp_out));

endmodule

// File: tb/sop_array_bench.sv
`timescale 1ns/1ps
module sop_array_bench;

    localparam int NR = 132;
    localparam int NC = 44;
    localparam int CH = NR * NC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_bit = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_out, oe_out;
    logic        ar_out, sp_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit          q[$];
    int          mst;          // 0 empty, 1 loading, 2 live
    logic [43:0] want [NR];

    always #5 clk = ~clk;

    sop_array u_sop_array (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
        .ded_in(ded_in), .fb_in(fb_in), .sum_out(sum_out), .oe_out(oe_out),
        .ar_out(ar_out), .sp_out(sp_out)
    );

    function automatic int nterms(int c);
        return 8 + 2 * ((c < 9 - c) ? c : 9 - c);
    endfunction

    function automatic int cbase(int c);
        int b = 1;
        for (int j = 0; j < c; j++) b += nterms(j) + 1;
        return b;
    endfunction

    function automatic bit row_val(int r, logic [43:0] lits);
        for (int k = 0; k < NC; k++)
            if (q[r*NC+k] && !lits[k]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic cmp(string tag, string what, logic [9:0] act, logic [9:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check(string tag);
        logic [9:0]  es, eo;
        logic        ea, ep;
        logic [43:0] lits;
        es = '0; eo = '0; ea = 0; ep = 0;
        if (mst == 2) begin
            for (int k = 0; k < 22; k++) begin
                lits[2*k]   = (k < 12) ? ded_in[k] : fb_in[k-12];
                lits[2*k+1] = ~lits[2*k];
            end
            ea = row_val(0, lits);
            ep = row_val(NR - 1, lits);
            for (int c = 0; c < 10; c++) begin
                eo[c] = row_val(cbase(c), lits);
                for (int t = 1; t <= nterms(c); t++)
                    if (row_val(cbase(c) + t, lits)) es[c] = 1'b1;
            end
            cmp({tag, " R3"}, "sum", sum_out, es);
            cmp({tag, " R4"}, "oe", oe_out, eo);
            cmp({tag, " R5"}, "ar/sp", {8'd0, ar_out, sp_out}, {8'd0, ea, ep});
        end else begin
            cmp({tag, " R8"}, "blank", sum_out | oe_out | {8'd0, ar_out, sp_out}, '0);
        end
    endtask

    // One clock: drive, settle, compare, then advance the model at the edge
    task automatic cyc(logic le, logic lb, logic [11:0] d, logic [9:0] f, string tag);
        cfg_load = le; cfg_bit = lb; ded_in = d; fb_in = f;
        #1;
        check(tag);
        @(posedge clk);
        if (le) begin
            q.push_front(lb);
            void'(q.pop_back());
            mst = 1;
        end else if (mst == 1) begin
            mst = 2;
        end
        @(negedge clk);
    endtask

    task automatic load_want(string tag);
        for (int i = CH - 1; i >= 0; i--)
            cyc(1'b1, want[i / NC][i % NC], 12'($urandom), 10'($urandom), tag);
    endtask

    task automatic run_rand(int n, string tag);
        for (int i = 0; i < n; i++)
            cyc(1'b0, 1'($urandom), 12'($urandom), 10'($urandom), tag);
    endtask

    task automatic fill_rand(int one_in);
        for (int r = 0; r < NR; r++)
            for (int k = 0; k < NC; k++)
                want[r][k] = (($urandom % one_in) == 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog act=running exp=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < CH; i++) q.push_back(1'b0);
        mst = 0;
        repeat (3) @(negedge clk);
        #1; check("reset R8");
        rst_n = 1'b1;
        @(negedge clk);

        // Empty state holds with load low (R9), bit ignored (R7)
        run_rand(6, "empty R9 R7");

        // All-zero configuration: every term empty, reads 1 (R2)
        for (int r = 0; r < NR; r++) want[r] = '0;
        load_want("load R6");
        run_rand(40, "empty-term R2");

        // Directed literal mapping and contradictory terms (R1, R2)
        for (int r = 0; r < NR; r++) want[r] = '0;
        for (int c = 0; c < 10; c++) begin
            want[cbase(c)][2*c] = 1'b1;
            want[cbase(c)+1][2*((c+1)%12)] = 1'b1;
            want[cbase(c)+1][2*(12+c)+1] = 1'b1;
            for (int t = 2; t <= nterms(c); t++) begin
                want[cbase(c)+t][2*(t%22)]   = 1'b1;
                want[cbase(c)+t][2*(t%22)+1] = 1'b1;
            end
        end
        want[0][22] = 1'b1; want[0][43] = 1'b1;
        want[NR-1][1] = 1'b1;
        load_want("load R6");
        run_rand(200, "literal R1 R10");

        // Load starting while live, then short aborted reloads (R9, R6)
        cyc(1'b1, 1'b1, 12'($urandom), 10'($urandom), "run-to-load R9");
        cyc(1'b1, 1'b0, 12'($urandom), 10'($urandom), "load R9");
        run_rand(60, "partial R6 R9");
        for (int p = 0; p < 4; p++) begin
            cyc(1'b1, 1'($urandom), 12'($urandom), 10'($urandom), "reload R9");
            run_rand(40, "reload R6 R9");
        end

        // Pseudo-random configurations of two densities (R6, R10)
        fill_rand(12);
        load_want("load R6");
        run_rand(300, "rand R6 R10 R7");
        fill_rand(40);
        load_want("load R6");
        run_rand(300, "rand R6 R10 R7");

        summary();
    end

endmodule